// File: doc/BRIEF.md
# Event-Driven PWM Timer

A single up-counter drives a bank of PWM outputs through programmable match events. Each event watches one match register and fires on a counter tick when the counter equals that register. Each output has a mask of events that drive it high and a mask of events that drive it low. A per-output rule decides the result when both masks hit in the same tick. A limit mask names the events that send the counter back to zero, so every output shares one period.

Software programs the block through a word-addressed register port: a write strobe with address and data, and a combinational read path. A typical PWM channel uses a period event as the limit. The period event sets the output and a duty event clears it; swapping the two inverts the polarity. Match registers have reload copies. While the counter runs, match updates land in the reload copy and are applied at the next wrap, so a period is never cut short by an update. The block leaves reset halted, with the counter and all outputs at zero.

Top module: `evpwm_timer`

## Requirements
- R1: After reset every output is 0, the counter (read at 0x040) is 0, the control word at 0x004 reads 0x4 (halted, prescaler 0), and the counter stays at 0 until the halt bit is cleared.
- R2: Control bit 2 at 0x004 halts the counter and freezes the outputs. Control bits 12:5 hold a prescale value p; while running, the counter advances exactly once every p+1 clocks.
- R3: Event k is programmed by a control word at 0x304+8k, whose low bits pick the match register it compares and whose bits 13:12 give its trigger mode. It fires only if that mode is 1 and the state word at 0x300+8k was last written nonzero. An event that fails either condition never changes any output.
- R4: If an event flagged in the limit mask at 0x008 (bit k for event k) fires on a tick, the counter goes to 0; on any other tick it goes up by 1. A limit event on match value P therefore gives a period of P+1 ticks.
- R5: Bit k of the word at 0x500+8n makes event k drive output n high, and bit k of the word at 0x504+8n makes it drive output n low. An output changes only at the clock edge that ends a tick on which an event fired.
- R6: Bits 2n+1:2n of the word at 0x058 apply when output n gets a high and a low request in the same tick: 0 keeps the output, 1 forces it high, 2 forces it low, 3 inverts it.
- R7: With a period limit event on match P setting an output and an event on match D below P clearing it, the output is high while the counter reads 0 to D, which is D+1 ticks out of every P+1. With the two roles swapped, the output is high while the counter reads D+1 to P.
- R8: A write to match register n at 0x100+4n replaces it at once while halted. While running, the same write goes to reload register n at 0x200+4n, and the match register keeps its value. On each limit wrap, every match register takes its reload value.
- R9: Config bit 7 at 0x000 suppresses the reload transfer on wraps; config bit 0 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | NOUT | PWM outputs |

## Verification
A register write takes effect at the clock edge in the middle of the bench's write task, and register reads are combinational. The bench therefore samples read data one time step after a falling edge. The counter and the outputs both change at the edge that ends a tick, so a sample at any falling edge shows the counter value and the output value for the same tick. Each PWM check ties the sampled output to the sampled counter value rather than to a cycle count. Reload effects are checked only after the bench has seen the counter go from a nonzero value to zero, which marks a wrap that the sample itself proves.

// File: rtl/evpwm_timer.sv
module evpwm_timer #(
  parameter int NOUT = 16,
  parameter int NEV  = 16,
  parameter int CW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [11:0]     reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [NOUT-1:0] pwm_out
);
  localparam int SW = (NEV > 1) ? $clog2(NEV) : 1;
  localparam int OW = (NOUT > 1) ? $clog2(NOUT) : 1;
  localparam int PW = 8;

  logic [CW-1:0]     count;
  logic [PW-1:0]     pre_q, pre_div;
  logic              halt, noreload;
  logic [NEV-1:0]    limit_m, ev_live, ev_hit;
  logic [2*NOUT-1:0] res_q;
  logic [CW-1:0]     match_r  [NEV];
  logic [CW-1:0]     reload_r [NEV];
  logic [SW-1:0]     ev_sel   [NEV];
  logic [1:0]        ev_comb  [NEV];
  logic [NEV-1:0]    set_m    [NOUT];
  logic [NEV-1:0]    clr_m    [NOUT];
  logic [NOUT-1:0]   out_q, out_d, set_any, clr_any;

  wire [3:0] region  = reg_addr[11:8];
  wire [5:0] widx    = reg_addr[7:2];
  wire [4:0] eidx    = reg_addr[7:3];
  wire       aligned = (reg_addr[1:0] == 2'b00);
  wire       widx_ok = aligned && (int'(widx) < NEV);
  wire       eev_ok  = aligned && (int'(eidx) < NEV);
  wire       eout_ok = aligned && (int'(eidx) < NOUT);
  wire       tick    = !halt && (pre_q == pre_div);
  wire       wrap    = |(ev_hit & limit_m);

  for (genvar k = 0; k < NEV; k++) begin : g_ev
    assign ev_hit[k] = tick && ev_live[k] && (ev_comb[k] == 2'd1) &&
                       (int'(ev_sel[k]) < NEV) && (count == match_r[ev_sel[k]]);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_req
    assign set_any[o] = |(ev_hit & set_m[o]);
    assign clr_any[o] = |(ev_hit & clr_m[o]);
  end

  always_comb begin
    for (int o = 0; o < NOUT; o++) begin
      out_d[o] = out_q[o];
      if (set_any[o] && clr_any[o]) begin
        case (res_q[2*o +: 2])
          2'd1:    out_d[o] = 1'b1;
          2'd2:    out_d[o] = 1'b0;
          2'd3:    out_d[o] = !out_q[o];
          default: out_d[o] = out_q[o];
        endcase
      end else if (set_any[o]) begin
        out_d[o] = 1'b1;
      end else if (clr_any[o]) begin
        out_d[o] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      pre_q <= '0;
      out_q <= '0;
    end else begin
      out_q <= out_d;
      if (halt || tick) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
      if (tick) count <= wrap ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt     <= 1'b1;
      noreload <= 1'b0;
      pre_div  <= '0;
      limit_m  <= '0;
      res_q    <= '0;
      ev_live  <= '0;
      for (int i = 0; i < NEV; i++) begin
        match_r[i]  <= '0;
        reload_r[i] <= '0;
        ev_sel[i]   <= '0;
        ev_comb[i]  <= '0;
      end
      for (int o = 0; o < NOUT; o++) begin
        set_m[o] <= '0;
        clr_m[o] <= '0;
      end
    end else begin
      if (tick && wrap && !noreload)
        for (int i = 0; i < NEV; i++) match_r[i] <= reload_r[i];
      if (reg_we) begin
        case (region)
          4'h0: case (reg_addr[7:0])
            8'h00: noreload <= reg_wdata[7];
            8'h04: begin
              halt    <= reg_wdata[2];
              pre_div <= reg_wdata[5 +: PW];
            end
            8'h08: limit_m <= reg_wdata[NEV-1:0];
            8'h58: res_q   <= reg_wdata[2*NOUT-1:0];
            default: ;
          endcase
          4'h1: if (widx_ok) begin
            if (halt) match_r[widx[SW-1:0]]  <= reg_wdata[CW-1:0];
            else      reload_r[widx[SW-1:0]] <= reg_wdata[CW-1:0];
          end
          4'h2: if (widx_ok) reload_r[widx[SW-1:0]] <= reg_wdata[CW-1:0];
          4'h3: if (eev_ok) begin
            if (reg_addr[2]) begin
              ev_sel[eidx[SW-1:0]]  <= reg_wdata[SW-1:0];
              ev_comb[eidx[SW-1:0]] <= reg_wdata[13:12];
            end else begin
              ev_live[eidx[SW-1:0]] <= |reg_wdata;
            end
          end
          4'h5: if (eout_ok) begin
            if (reg_addr[2]) clr_m[eidx[OW-1:0]] <= reg_wdata[NEV-1:0];
            else             set_m[eidx[OW-1:0]] <= reg_wdata[NEV-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (region)
      4'h0: case (reg_addr[7:0])
        8'h00: reg_rdata = {24'b0, noreload, 6'b0, 1'b1};
        8'h04: begin
          reg_rdata[2]       = halt;
          reg_rdata[5 +: PW] = pre_div;
        end
        8'h08: reg_rdata[NEV-1:0]    = limit_m;
        8'h40: reg_rdata[CW-1:0]     = count;
        8'h58: reg_rdata[2*NOUT-1:0] = res_q;
        default: ;
      endcase
      4'h1: if (widx_ok) reg_rdata[CW-1:0] = match_r[widx[SW-1:0]];
      4'h2: if (widx_ok) reg_rdata[CW-1:0] = reload_r[widx[SW-1:0]];
      4'h3: if (eev_ok) begin
        if (reg_addr[2]) begin
          reg_rdata[SW-1:0] = ev_sel[eidx[SW-1:0]];
          reg_rdata[13:12]  = ev_comb[eidx[SW-1:0]];
        end else begin
          reg_rdata[0] = ev_live[eidx[SW-1:0]];
        end
      end
      4'h5: if (eout_ok) begin
        if (reg_addr[2]) reg_rdata[NEV-1:0] = clr_m[eidx[OW-1:0]];
        else             reg_rdata[NEV-1:0] = set_m[eidx[OW-1:0]];
      end
      default: ;
    endcase
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/evpwm_timer_chk.sv
module evpwm_timer_chk #(
  parameter int NOUT = 16,
  parameter int CW   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wrap,
  input logic              halt,
  input logic [CW-1:0]     count,
  input logic [NOUT-1:0]   out_q,
  input logic [NOUT-1:0]   set_any,
  input logic [NOUT-1:0]   clr_any,
  input logic [2*NOUT-1:0] res_q
);
  assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(count));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wrap) |=> (count == '0));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (count == $past(count) + 1'b1));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_q));

  for (genvar o = 0; o < NOUT; o++) begin : g_chk
    assert_set_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_any[o] && !clr_any[o]) |=> out_q[o]);
    assert_clr_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_any[o] && !set_any[o]) |=> !out_q[o]);
    assert_conflict_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_any[o] && clr_any[o] && res_q[2*o +: 2] == 2'd1) |=> out_q[o]);
    assert_conflict_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_any[o] && clr_any[o] && res_q[2*o +: 2] == 2'd2) |=> !out_q[o]);
    assert_conflict_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_any[o] && clr_any[o] && res_q[2*o +: 2] == 2'd3) |=> (out_q[o] != $past(out_q[o])));
  end
endmodule

bind evpwm_timer evpwm_timer_chk #(.NOUT(NOUT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .halt(halt),
  .count(count), .out_q(out_q), .set_any(set_any), .clr_any(clr_any), .res_q(res_q)
);

// File: tb/sim_evpwm_timer.sv
module sim_evpwm_timer;
  localparam int NOUT = 16;
  localparam logic [11:0] CNT_A = 12'h040;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [11:0]     reg_addr = CNT_A;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NOUT-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0]     cur_c;
  logic [NOUT-1:0] cur_o;

  always #5 clk = ~clk;

  evpwm_timer #(.NOUT(NOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = CNT_A;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = CNT_A;
  endtask

  task automatic sample();
    @(negedge clk);
    #1 cur_c = reg_rdata; cur_o = pwm_out;
  endtask

  task automatic wait_wrap();
    int n = 0;
    sample();
    while (cur_c == 0 && n < 200) begin sample(); n++; end
    while (cur_c != 0 && n < 400) begin sample(); n++; end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 outputs after reset", 32'(pwm_out), 32'h0);
    rd(CNT_A, d);   check("R1 counter after reset", d, 32'h0);
    rd(12'h004, d); check("R1 control after reset", d, 32'h4);
    repeat (5) @(negedge clk);
    rd(CNT_A, d);   check("R1 counter held while halted", d, 32'h0);
  endtask

  task automatic t_pwm();
    logic [31:0] prev;
    wr(12'h100, 9); wr(12'h200, 9);
    wr(12'h104, 3); wr(12'h204, 3);
    wr(12'h108, 6); wr(12'h208, 6);
    wr(12'h304, 32'h1000); wr(12'h300, 32'hFFFF_FFFF);
    wr(12'h30C, 32'h1001); wr(12'h308, 32'h1);
    wr(12'h314, 32'h1002); wr(12'h310, 32'h1);
    wr(12'h008, 32'h1);
    wr(12'h500, 32'h1);    wr(12'h504, 32'h2);
    wr(12'h508, 32'h4);    wr(12'h50C, 32'h1);
    wr(12'h058, 32'h9);
    wr(12'h004, 32'h0);
    wait_wrap();
    prev = 9;
    for (int s = 0; s < 20; s++) begin
      if (s > 0) sample();
      check("R4 wrap sequence", cur_c, (prev == 9) ? 32'd0 : prev + 1);
      check("R7 normal polarity high time", 32'(cur_o[0]), 32'(cur_c <= 3));
      check("R7 inverted polarity", 32'(cur_o[1]), 32'(cur_c >= 7));
      check("R5 unrelated output idle", 32'(cur_o[2]), 32'h0);
      prev = cur_c;
    end
  endtask

  task automatic t_prescale_halt();
    int changes = 0;
    logic [31:0] first, last;
    logic [NOUT-1:0] o_first;
    wr(12'h004, 32'h40);
    sample();
    last = cur_c;
    for (int s = 0; s < 30; s++) begin
      sample();
      if (cur_c != last) changes++;
      last = cur_c;
    end
    check("R2 prescale 2 gives one count per three clocks", 32'(changes), 32'd10);
    wr(12'h004, 32'h44);
    sample(); first = cur_c; o_first = cur_o;
    repeat (6) sample();
    check("R2 counter frozen by halt", cur_c, first);
    check("R2 outputs frozen by halt", 32'(cur_o), 32'(o_first));
  endtask

  task automatic t_reload();
    logic [31:0] d;
    wr(12'h104, 2);
    rd(12'h104, d); check("R8 halted write is immediate", d, 32'd2);
    rd(12'h204, d); check("R8 halted write leaves reload", d, 32'd3);
    wr(12'h004, 32'h0);
    wait_wrap();
    wr(12'h104, 1);
    rd(12'h204, d); check("R8 running write lands in reload", d, 32'd1);
    rd(12'h104, d); check("R8 running write leaves match", d, 32'd3);
    wait_wrap();
    for (int s = 0; s < 10; s++) begin
      if (s > 0) sample();
      check("R8 new duty from wrap on", 32'(cur_o[0]), 32'(cur_c <= 1));
    end
    rd(12'h104, d); check("R8 match took reload at wrap", d, 32'd1);
  endtask

  task automatic t_noreload();
    logic [31:0] d;
    wr(12'h000, 32'h80);
    rd(12'h000, d); check("R9 config readback", d, 32'h81);
    wr(12'h104, 5);
    wait_wrap();
    wait_wrap();
    rd(12'h104, d); check("R9 no transfer while suppressed", d, 32'd1);
    rd(12'h204, d); check("R9 reload holds pending value", d, 32'd5);
    wait_wrap();
    for (int s = 0; s < 10; s++) begin
      if (s > 0) sample();
      check("R9 duty unchanged while suppressed", 32'(cur_o[0]), 32'(cur_c <= 1));
    end
    wr(12'h000, 32'h0);
    wait_wrap();
    rd(12'h104, d); check("R9 transfer resumes", d, 32'd5);
  endtask

  task automatic t_conflict();
    logic expv;
    wr(12'h004, 32'h4);
    wr(12'h10C, 9); wr(12'h20C, 9);
    wr(12'h31C, 32'h1003); wr(12'h318, 32'h1);
    wr(12'h510, 32'h1); wr(12'h514, 32'h8);
    wr(12'h058, 32'h19);
    wr(12'h004, 32'h0);
    wait_wrap(); wait_wrap();
    for (int s = 0; s < 20; s++) begin
      sample(); check("R6 conflict rule set", 32'(cur_o[2]), 32'h1);
    end
    wr(12'h058, 32'h29);
    wait_wrap();
    for (int s = 0; s < 20; s++) begin
      sample(); check("R6 conflict rule clear", 32'(cur_o[2]), 32'h0);
    end
    wr(12'h058, 32'h39);
    wait_wrap();
    expv = cur_o[2];
    for (int s = 0; s < 30; s++) begin
      sample();
      if (cur_c == 0) expv = !expv;
      check("R6 conflict rule toggle", 32'(cur_o[2]), 32'(expv));
    end
    wr(12'h058, 32'h09);
    wait_wrap();
    expv = cur_o[2];
    for (int s = 0; s < 25; s++) begin
      sample(); check("R6 conflict rule hold", 32'(cur_o[2]), 32'(expv));
    end
  endtask

  task automatic t_event_gate();
    wr(12'h324, 32'h1002);
    wr(12'h518, 32'h10);
    for (int s = 0; s < 25; s++) begin
      sample(); check("R3 event with zero state word is off", 32'(cur_o[3]), 32'h0);
    end
    wr(12'h320, 32'h1);
    repeat (12) sample();
    check("R3 event enabled by state word", 32'(cur_o[3]), 32'h1);
    wr(12'h328, 32'h1);
    wr(12'h32C, 32'h2002);
    wr(12'h520, 32'h20);
    for (int s = 0; s < 25; s++) begin
      sample(); check("R3 event with mode 2 is off", 32'(cur_o[4]), 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pwm();
    t_prescale_halt();
    t_reload();
    t_noreload();
    t_conflict();
    t_event_gate();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule